// File: doc/BRIEF.md
# Serial Transmit Channel with Automatic Request-to-Send Release

This block is the transmit side of one asynchronous serial channel. Software writes a byte into a one-entry holding register. The byte moves into a shift register as soon as that register is free, and it leaves on the line as one start bit, eight data bits sent least significant bit first, and one or two stop bits. A baud tick input advances the line, and each bit lasts `OVS` ticks.

An output-port bit drives an active-low request-to-send pin. Software sets and clears this bit with register writes. When automatic release is enabled, the block clears the bit by itself one bit time after the last stop bit of the final queued character, so the end of a message also ends the request. A status input from the receiver says whether the receiver has also claimed request-to-send control. When it has, the automatic release is switched off and the bit is left alone.

A mode register also selects how the pins are routed. The choices are normal operation, echo of the received line, internal loopback of the transmitter into the receive path, and remote loopback of the receive pin straight to the transmit pin.

Top module: `uart_tx_rts`

## Requirements
- R1: After reset the mode register reads 0x00, `tx_pin` is 1 and `rts_n` is 1.
- R2: A write to address 0 loads the mode register while `module_stop` is 0, and `rd_data` returns the mode register. While `module_stop` is 1, writes to address 0 are ignored and `rd_data` reads 0x00.
- R3: A byte written to address 1 is sent as a 0 start bit, then data bits 0 to 7, then stop bits at 1, each bit lasting 16 baud ticks. Mode bit 3 selects the stop length: 0 gives one stop bit and 1 gives two.
- R4: A byte written while the shift register is busy waits in the holding register. It is sent right after the current frame's stop bits, with no idle gap.
- R5: A write to address 2 sets the output-port bit and a write to address 3 clears it. `rts_n` is always the inverse of that bit.
- R6: With mode bit 5 at 1 and `rx_rts_ctl` at 0, the output-port bit clears 16 baud ticks after the last stop bit ends, once both the holding and shift registers are empty. It does not clear earlier.
- R7: A write to the holding register before that 16-tick delay ends cancels the release. The bit stays set through the new frame.
- R8: While `rx_rts_ctl` is 1, the automatic release never clears the output-port bit.
- R9: With mode bit 5 at 0, draining the transmitter leaves the output-port bit unchanged.
- R10: Mode bits 7:6 = 01 (echo): `tx_pin` follows `rx_pin`, `rx_int` follows `rx_pin`, and the transmitter is cut off from the pin.
- R11: Mode bits 7:6 = 10 (local loopback): `tx_pin` stays at 1 and `rx_int` carries the transmitter's serial frame.
- R12: Mode bits 7:6 = 11 (remote loopback): `tx_pin` follows `rx_pin` and `rx_int` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| module_stop | input | 1 | Serial module stopped; blocks mode register access |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 holding, 2 set port bit, 3 clear port bit |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Mode register read value |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_pin | input | 1 | Serial receive pin |
| rx_rts_ctl | input | 1 | Receiver also claims request-to-send control |
| tx_pin | output | 1 | Serial transmit pin |
| rx_int | output | 1 | Routed line toward the receiver |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The bench builds the block with its default parameters: 8 data bits and 16 ticks per bit. It varies the baud tick divider between 1, 2 and 3 clocks. With one clock per tick, all 256 byte values fit into a short run, so every data pattern is swept with one stop bit. Slower dividers move the tick phase relative to the write strobes, and they check the two-stop-bit frames, the back-to-back gap and the release and cancel windows with margins wide enough to hold for any phase.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'b00,
    CH_ECHO   = 2'b01,
    CH_LOCAL  = 2'b10,
    CH_REMOTE = 2'b11
  } ch_mode_e;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_HOLD   = 2'd1;
  localparam logic [1:0] ADDR_OP_SET = 2'd2;
  localparam logic [1:0] ADDR_OP_CLR = 2'd3;

  localparam int MODE_W      = 8;
  localparam int MODE_CH_HI  = 7;
  localparam int MODE_CH_LO  = 6;
  localparam int MODE_AUTO   = 5;
  localparam int MODE_STOP2  = 3;
endpackage

// File: rtl/uart_mode_reg.sv
module uart_mode_reg
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              module_stop,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q,
  output logic [MODE_W-1:0] rd_data
);
  logic [MODE_W-1:0] mode_d;
  logic              mode_we;

  assign mode_we = wr_en && (wr_addr == ADDR_MODE) && !module_stop;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign rd_data = module_stop ? '0 : mode_q;

  // R2
  stopped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (module_stop && wr_en && wr_addr == ADDR_MODE) |=> $stable(mode_q));
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              two_stop,
  output logic              tx_ser,
  output logic              busy_o,
  output logic              hold_full_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int TICK_W  = $clog2(OVS);
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_q, hold_d;
  logic               hold_full_q, hold_full_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   bits_q, bits_d;
  logic [TICK_W-1:0]  tick_q, tick_d;
  logic               busy_q, busy_d;
  logic               load;

  assign load = !busy_q && hold_full_q;

  always_comb begin
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    sh_d        = sh_q;
    bits_d      = bits_q;
    tick_d      = tick_q;
    busy_d      = busy_q;
    if (busy_q && baud_tick) begin
      if (tick_q == TICK_W'(OVS - 1)) begin
        tick_d = '0;
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        bits_d = bits_q - CNT_W'(1);
        if (bits_q == CNT_W'(1)) busy_d = 1'b0;
      end else begin
        tick_d = tick_q + TICK_W'(1);
      end
    end
    if (load) begin
      sh_d        = {2'b11, hold_q, 1'b0};
      bits_d      = two_stop ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
      tick_d      = '0;
      busy_d      = 1'b1;
      hold_full_d = 1'b0;
    end
    if (hold_wr) begin
      hold_d      = hold_data;
      hold_full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      sh_q        <= '1;
      bits_q      <= '0;
      tick_q      <= '0;
      busy_q      <= 1'b0;
    end else begin
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      sh_q        <= sh_d;
      bits_q      <= bits_d;
      tick_q      <= tick_d;
      busy_q      <= busy_d;
    end
  end

  assign tx_ser      = busy_q ? sh_q[0] : 1'b1;
  assign busy_o      = busy_q;
  assign hold_full_o = hold_full_q;

  // R4
  load_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(hold_full_q));

  // R3
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !tx_ser);
endmodule

// File: rtl/uart_rts_ctrl.sv
module uart_rts_ctrl #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic op_set,
  input  logic op_clr,
  input  logic auto_req,
  input  logic rx_rts_ctl,
  input  logic tx_drained,
  input  logic hold_wr,
  output logic op_q
);
  localparam int DLY_W = $clog2(OVS);

  logic [DLY_W-1:0] dly_q, dly_d;
  logic             op_d;
  logic             auto_en;
  logic             armed;

  assign auto_en = auto_req && !rx_rts_ctl;
  assign armed   = auto_en && tx_drained && op_q && !hold_wr;

  always_comb begin
    dly_d = dly_q;
    op_d  = op_q;
    if (!armed) begin
      dly_d = '0;
    end else if (baud_tick) begin
      if (dly_q == DLY_W'(OVS - 1)) begin
        op_d  = 1'b0;
        dly_d = '0;
      end else begin
        dly_d = dly_q + DLY_W'(1);
      end
    end
    if (op_clr) op_d = 1'b0;
    if (op_set) op_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      op_q  <= 1'b0;
    end else begin
      dly_q <= dly_d;
      op_q  <= op_d;
    end
  end

  // R6
  release_when_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(op_q) && !$past(op_clr)) |-> $past(tx_drained && auto_en));

  // R8
  rx_owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && rx_rts_ctl && !op_clr) |=> op_q);

  // R9
  no_auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && !auto_req && !op_clr) |=> op_q);
endmodule

// File: rtl/uart_loop_route.sv
module uart_loop_route
  import uart_tx_pkg::*;
(
  input  ch_mode_e ch_mode,
  input  logic     tx_ser,
  input  logic     rx_pin,
  output logic     tx_pin,
  output logic     rx_int
);
  always_comb begin
    unique case (ch_mode)
      CH_ECHO:   begin tx_pin = rx_pin; rx_int = rx_pin; end
      CH_LOCAL:  begin tx_pin = 1'b1;   rx_int = tx_ser; end
      CH_REMOTE: begin tx_pin = rx_pin; rx_int = 1'b1;   end
      default:   begin tx_pin = tx_ser; rx_int = rx_pin; end
    endcase
  end
endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        module_stop,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  input  logic        baud_tick,
  input  logic        rx_pin,
  input  logic        rx_rts_ctl,
  output logic        tx_pin,
  output logic        rx_int,
  output logic        rts_n
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [MODE_W-1:0] mode_q;
  logic              hold_wr, op_set, op_clr;
  logic              tx_ser, busy, hold_full, op_bit;
  ch_mode_e          ch_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign hold_wr = wr_en && (wr_addr == ADDR_HOLD);
  assign op_set  = wr_en && (wr_addr == ADDR_OP_SET);
  assign op_clr  = wr_en && (wr_addr == ADDR_OP_CLR);
  assign ch_mode = ch_mode_e'(mode_q[MODE_CH_HI:MODE_CH_LO]);

  uart_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n_s), .module_stop(module_stop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .rd_data(rd_data)
  );

  uart_tx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_core (
    .clk(clk), .rst_n(rst_n_s), .baud_tick(baud_tick),
    .hold_wr(hold_wr), .hold_data(wr_data[DATA_W-1:0]),
    .two_stop(mode_q[MODE_STOP2]), .tx_ser(tx_ser),
    .busy_o(busy), .hold_full_o(hold_full)
  );

  uart_rts_ctrl #(.OVS(OVS)) u_rts (
    .clk(clk), .rst_n(rst_n_s), .baud_tick(baud_tick),
    .op_set(op_set), .op_clr(op_clr), .auto_req(mode_q[MODE_AUTO]),
    .rx_rts_ctl(rx_rts_ctl), .tx_drained(!busy && !hold_full),
    .hold_wr(hold_wr), .op_q(op_bit)
  );

  uart_loop_route u_route (
    .ch_mode(ch_mode), .tx_ser(tx_ser), .rx_pin(rx_pin),
    .tx_pin(tx_pin), .rx_int(rx_int)
  );

  assign rts_n = ~op_bit;

  // R11
  local_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q[MODE_CH_HI:MODE_CH_LO] == CH_LOCAL) |-> tx_pin);

  // R10
  echo_route_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q[MODE_CH_HI:MODE_CH_LO] == CH_ECHO) |-> (tx_pin == rx_pin));

  // R12
  remote_rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q[MODE_CH_HI:MODE_CH_LO] == CH_REMOTE) |-> (rx_int && tx_pin == rx_pin));
endmodule

// File: tb/uart_tx_rts_tb.sv
module uart_tx_rts_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       module_stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       baud_tick = 1'b0;
  logic       rx_pin = 1'b1;
  logic       rx_rts_ctl = 1'b0;
  logic       tx_pin, rx_int, rts_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_p = 1;
  int tick_cnt = 0;
  bit mon_local = 1'b0;
  int low_seen = 0;

  uart_tx_rts dut_i (
    .clk(clk), .rst_n(rst_n), .module_stop(module_stop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .baud_tick(baud_tick), .rx_pin(rx_pin), .rx_rts_ctl(rx_rts_ctl),
    .tx_pin(tx_pin), .rx_int(rx_int), .rts_n(rts_n)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_cnt >= tick_p - 1) begin baud_tick <= 1'b1; tick_cnt <= 0; end
    else begin baud_tick <= 1'b0; tick_cnt <= tick_cnt + 1; end
    if (mon_local && tx_pin !== 1'b1) low_seen <= low_seen + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic lvl(input int sel);
    return (sel != 0) ? rx_int : tx_pin;
  endfunction

  task automatic recv(input int sel, input int nstop, output logic [7:0] d,
                      output bit ok, output int gap);
    gap = 0; ok = 1'b1; d = 8'h00;
    while (lvl(sel) !== 1'b0 && gap < 4000) begin @(negedge clk); gap++; end
    if (gap >= 4000) ok = 1'b0;
    repeat (8 * tick_p) @(negedge clk);
    if (lvl(sel) !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (16 * tick_p) @(negedge clk);
      d[i] = lvl(sel);
    end
    for (int s = 0; s < nstop; s++) begin
      repeat (16 * tick_p) @(negedge clk);
      if (lvl(sel) !== 1'b1) ok = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] a;
    bit ok;
    int gap;
    int mism;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rd_data == 8'h00, "R1 mode", rd_data, 8'h00);
    chk(tx_pin == 1'b1, "R1 tx", tx_pin, 1);
    chk(rts_n == 1'b1, "R1 rts", rts_n, 1);

    // R2 mode access and stop gating
    wr(2'd0, 8'h08);
    chk(rd_data == 8'h08, "R2 write", rd_data, 8'h08);
    module_stop = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R2 stopped read", rd_data, 8'h00);
    wr(2'd0, 8'hC5);
    module_stop = 1'b0;
    @(negedge clk);
    chk(rd_data == 8'h08, "R2 stopped write", rd_data, 8'h08);

    // R3 all byte values, one stop bit, one clock per tick
    wr(2'd0, 8'h00);
    tick_p = 1;
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v));
      recv(0, 1, d, ok, gap);
      chk(ok && d == 8'(v), "R3 frame", {23'd0, ok, d}, {24'd1, 8'(v)});
    end

    // R3 two stop bits, slower ticks
    wr(2'd0, 8'h08);
    tick_p = 3;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      a = 8'(k * 17 + 3);
      wr(2'd1, a);
      recv(0, 2, d, ok, gap);
      chk(ok && d == a, "R3 frame 2stop", {23'd0, ok, d}, {24'd1, a});
    end

    // R4 back-to-back through holding register; gap tells the stop length
    tick_p = 2;
    for (int sb = 0; sb < 2; sb++) begin
      wr(2'd0, (sb != 0) ? 8'h08 : 8'h00);
      repeat (400) @(negedge clk);
      wr(2'd1, 8'h3C);
      wr(2'd1, 8'hC3);
      recv(0, 1, d, ok, gap);
      chk(ok && d == 8'h3C, "R4 first", d, 8'h3C);
      recv(0, 1, d, ok, gap);
      chk(ok && d == 8'hC3, "R4 second", d, 8'hC3);
      if (sb == 0)
        chk(gap >= 7 * tick_p && gap <= 9 * tick_p + 2, "R4 gap 1stop", gap, 8 * tick_p);
      else
        chk(gap >= 23 * tick_p && gap <= 25 * tick_p + 2, "R3 gap 2stop", gap, 24 * tick_p);
    end
    repeat (400) @(negedge clk);

    // R5 manual set and clear
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    chk(rts_n == 1'b0, "R5 set", rts_n, 0);
    wr(2'd3, 8'h00);
    chk(rts_n == 1'b1, "R5 clr", rts_n, 1);

    // R6 automatic release, both stop lengths
    for (int sb = 0; sb < 2; sb++) begin
      wr(2'd0, (sb != 0) ? 8'h28 : 8'h20);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h5A);
      recv(0, sb + 1, d, ok, gap);
      chk(ok && d == 8'h5A, "R6 frame", d, 8'h5A);
      repeat (4 * tick_p) @(negedge clk);
      chk(rts_n == 1'b0, "R6 held at stop", rts_n, 0);
      repeat (16 * tick_p) @(negedge clk);
      chk(rts_n == 1'b0, "R6 held in delay", rts_n, 0);
      repeat (12 * tick_p) @(negedge clk);
      chk(rts_n == 1'b1, "R6 released", rts_n, 1);
    end

    // R7 cancel by a new write inside the delay
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h11);
    recv(0, 1, d, ok, gap);
    repeat (12 * tick_p) @(negedge clk);
    wr(2'd1, 8'h22);
    recv(0, 1, d, ok, gap);
    chk(ok && d == 8'h22, "R7 frame", d, 8'h22);
    chk(rts_n == 1'b0, "R7 kept", rts_n, 0);
    repeat (32 * tick_p) @(negedge clk);
    chk(rts_n == 1'b1, "R7 later release", rts_n, 1);

    // R8 receiver owns request-to-send
    rx_rts_ctl = 1'b1;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h77);
    recv(0, 1, d, ok, gap);
    repeat (40 * tick_p) @(negedge clk);
    chk(rts_n == 1'b0, "R8 unchanged", rts_n, 0);
    rx_rts_ctl = 1'b0;
    wr(2'd3, 8'h00);

    // R9 automatic release off
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h99);
    recv(0, 1, d, ok, gap);
    repeat (40 * tick_p) @(negedge clk);
    chk(rts_n == 1'b0, "R9 unchanged", rts_n, 0);
    wr(2'd3, 8'h00);

    // R10 echo
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h00);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      rx_pin = logic'((i >> (i % 3)) & 1);
      #1;
      if (tx_pin !== rx_pin || rx_int !== rx_pin) mism++;
      @(negedge clk);
    end
    chk(mism == 0, "R10 echo", mism, 0);
    rx_pin = 1'b1;
    repeat (200 * tick_p) @(negedge clk);

    // R11 local loopback
    wr(2'd0, 8'h80);
    rx_pin = 1'b0;
    @(negedge clk);
    low_seen = 0;
    mon_local = 1'b1;
    wr(2'd1, 8'hA5);
    recv(1, 1, d, ok, gap);
    chk(ok && d == 8'hA5, "R11 loop data", d, 8'hA5);
    mon_local = 1'b0;
    chk(low_seen == 0, "R11 tx idle", low_seen, 0);
    rx_pin = 1'b1;
    repeat (40 * tick_p) @(negedge clk);

    // R12 remote loopback
    wr(2'd0, 8'hC0);
    wr(2'd1, 8'h00);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      rx_pin = logic'((i * 5 >> 2) & 1);
      #1;
      if (tx_pin !== rx_pin || rx_int !== 1'b1) mism++;
      @(negedge clk);
    end
    chk(mism == 0, "R12 remote", mism, 0);
    rx_pin = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule